// File: doc/BRIEF.md
# Link Power State Controller

This block decides the operating state of a display-link redriver/retimer and drives the enables that follow from it. It looks at the output-enable pin, the sink hot-plug-detect level, a signal-enable input, a clock-valid flag from the clock detector, a mode strap that selects retimer or redriver operation, and a software power-down bit. From these it selects power down, standby or normal, and it turns the data-lane receivers, the clock receiver, the transmitters, the DDC path, the ARC path and the control-bus interface on or off to match.

The software power-down bit sits behind a simple register-write strobe. A single flag at a fixed address and bit position forces power down while the output-enable pin and hot-plug detect are both high. Each rising edge of output-enable produces a one-cycle register-file reset pulse. That pulse also clears the software flag. The source hot-plug-detect output is a direct copy of the sink input. The state is registered and is reported as a two-bit status code.

Top module: `link_pwr_ctrl`

## Requirements
- R1: While `oePin` is low, the clock edge that samples it puts `linkState` to 00 (power down) and drives every enable low, `i2cEn` included.
- R2: With `oePin` high and `hpdSink` low, the state is power down, all path enables are low and `i2cEn` is high.
- R3: A write with `regWrAddr` = 0x09 stores bit 3 of `regWrData` as the software power-down flag. While the flag is 1, the state is power down with `i2cEn` high, even with `oePin` and `hpdSink` both high. Writing 0 to the flag releases it. A write to any other address, or with bit 3 clear, does not set it.
- R4: In retimer mode (`retimerMode` = 1), with `oePin` and `hpdSink` high, the state is standby if the synchronized clock-valid flag is low or `sigEn` is low. In standby `dataRxEn` is all zero, `clkRxEn`, `ddcEn` and `arcEn` are high, and `txEn` is low.
- R5: In retimer mode, with `oePin`, `hpdSink`, `sigEn` and the synchronized clock-valid flag all high, the state is normal and every enable is high.
- R6: In redriver mode (`retimerMode` = 0), with `oePin` and `hpdSink` high and the software flag clear, the state is normal whatever the values of `clkValidRaw` and `sigEn`.
- R7: `txEn` is low in every state other than normal, so the transmit outputs are high-impedance.
- R8: A low-to-high change of `oePin` raises `regReset` for exactly one cycle, starting at the first edge that samples the high level. The pulse also clears the software power-down flag.
- R9: `hpdSource` equals `hpdSink` at all times, with no clock delay.
- R10: `linkState` encodes power down as 00, standby as 01 and normal as 10. The value 11 never appears.
- R11: `clkValidRaw` passes through a two-flop synchronizer. A change of `clkValidRaw` shows in `linkState` at the third rising edge after it.
- R12: While `rstN` is low, `linkState` is 00, `regReset` is low and the software flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oePin | input | 1 | Output-enable pin; low forces power down |
| hpdSink | input | 1 | Hot-plug detect from the sink side |
| sigEn | input | 1 | Signal-enable input |
| clkValidRaw | input | 1 | Clock-valid flag from the clock detector, asynchronous |
| retimerMode | input | 1 | 1 = retimer, 0 = redriver |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 8 | Register write address |
| regWrData | input | 8 | Register write data |
| hpdSource | output | 1 | Hot-plug detect toward the source |
| dataRxEn | output | 3 | Per-lane data receiver enables |
| clkRxEn | output | 1 | Clock-lane receiver enable |
| txEn | output | 1 | Transmitter enable; low means high-impedance outputs |
| ddcEn | output | 1 | DDC path enable |
| arcEn | output | 1 | ARC path enable |
| i2cEn | output | 1 | Control-bus interface enable |
| regReset | output | 1 | One-cycle register-file reset pulse |
| linkState | output | 2 | Current state code |

## Verification
The bench builds the block with its default parameters: three data lanes, the power-down flag at bit 3 of address 0x09, and a two-stage synchronizer. With three lanes, the all-zero and all-one lane-enable patterns can be told apart from partial patterns. The fixed address and bit let the bench aim writes at the flag, at a neighbouring address and at the other bits of the byte. The two-stage depth gives the clock-valid path a fixed three-edge latency, which the bench probes one edge before it ends and again at the edge where it ends.

// File: rtl/link_pwr_pkg.sv
package link_pwr_pkg;

  typedef enum logic [1:0] {
    LS_PWRDN = 2'b00,
    LS_STBY  = 2'b01,
    LS_NORM  = 2'b10
  } linkState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic       regResetStb;  // one-cycle pulse after an OE rising edge
    logic       oeSeen;       // registered OE level
    linkState_e state;        // registered link state
  } ctrlStrobe_t;

endpackage

// File: rtl/link_pwr_datapath.sv
module link_pwr_datapath
  import link_pwr_pkg::*;
#(
  parameter int NUM_DATA_LANES = 3,
  parameter int ADDR_W         = 8,
  parameter int DATA_W         = 8,
  parameter int PD_REG_ADDR    = 9,
  parameter int PD_BIT_POS     = 3,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      clkValidRaw,
  input  logic                      regWrEn,
  input  logic [ADDR_W-1:0]         regWrAddr,
  input  logic [DATA_W-1:0]         regWrData,
  input  ctrlStrobe_t               strobe,
  output logic                      clkValidSync,
  output logic                      pdFlag,
  output logic [NUM_DATA_LANES-1:0] dataRxEn,
  output logic                      clkRxEn,
  output logic                      txEn,
  output logic                      ddcEn,
  output logic                      arcEn,
  output logic                      i2cEn
);

  localparam logic [ADDR_W-1:0] PdAddr = ADDR_W'(PD_REG_ADDR);

  // clock-valid synchronizer chain
  logic [SYNC_STAGES-1:0] syncChain;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= clkValidRaw;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[s] <= 1'b0;
          else       syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  assign clkValidSync = syncChain[SYNC_STAGES-1];

  // software power-down flag
  logic pdWrHit;
  assign pdWrHit = regWrEn && (regWrAddr == PdAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    pdFlag <= 1'b0;
    else if (strobe.regResetStb)  pdFlag <= 1'b0;
    else if (pdWrHit)             pdFlag <= regWrData[PD_BIT_POS];
  end

  // enable decode from the registered state
  logic isNorm, isStby;
  assign isNorm = (strobe.state == LS_NORM);
  assign isStby = (strobe.state == LS_STBY);

  generate
    for (genvar g = 0; g < NUM_DATA_LANES; g++) begin : gLane
      assign dataRxEn[g] = isNorm;
    end
  endgenerate

  assign clkRxEn = isNorm || isStby;
  assign txEn    = isNorm;
  assign ddcEn   = isNorm || isStby;
  assign arcEn   = isNorm || isStby;
  assign i2cEn   = strobe.oeSeen;

endmodule

// File: rtl/link_pwr_ctrl_fsm.sv
module link_pwr_ctrl_fsm
  import link_pwr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        oePin,
  input  logic        hpdSink,
  input  logic        sigEn,
  input  logic        retimerMode,
  input  logic        clkValidSync,
  input  logic        pdFlag,
  output ctrlStrobe_t strobe
);

  logic       oePrev;
  logic       resetPulse;
  linkState_e stateQ, stateD;

  // next-state decode; OE low has top priority
  always_comb begin
    if (!oePin)                       stateD = LS_PWRDN;
    else if (!hpdSink || pdFlag)      stateD = LS_PWRDN;
    else if (!retimerMode)            stateD = LS_NORM;
    else if (clkValidSync && sigEn)   stateD = LS_NORM;
    else                              stateD = LS_STBY;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= LS_PWRDN;
      oePrev     <= 1'b0;
      resetPulse <= 1'b0;
    end else begin
      stateQ     <= stateD;
      oePrev     <= oePin;
      resetPulse <= oePin && !oePrev;
    end
  end

  assign strobe.state       = stateQ;
  assign strobe.oeSeen      = oePrev;
  assign strobe.regResetStb = resetPulse;

endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl
  import link_pwr_pkg::*;
#(
  parameter int NUM_DATA_LANES = 3,
  parameter int ADDR_W         = 8,
  parameter int DATA_W         = 8,
  parameter int PD_REG_ADDR    = 9,
  parameter int PD_BIT_POS     = 3,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      oePin,
  input  logic                      hpdSink,
  input  logic                      sigEn,
  input  logic                      clkValidRaw,
  input  logic                      retimerMode,
  input  logic                      regWrEn,
  input  logic [ADDR_W-1:0]         regWrAddr,
  input  logic [DATA_W-1:0]         regWrData,
  output logic                      hpdSource,
  output logic [NUM_DATA_LANES-1:0] dataRxEn,
  output logic                      clkRxEn,
  output logic                      txEn,
  output logic                      ddcEn,
  output logic                      arcEn,
  output logic                      i2cEn,
  output logic                      regReset,
  output logic [1:0]                linkState
);

  ctrlStrobe_t strobe;
  logic        clkValidSync;
  logic        pdFlag;

  link_pwr_ctrl_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .oePin        (oePin),
    .hpdSink      (hpdSink),
    .sigEn        (sigEn),
    .retimerMode  (retimerMode),
    .clkValidSync (clkValidSync),
    .pdFlag       (pdFlag),
    .strobe       (strobe)
  );

  link_pwr_datapath #(
    .NUM_DATA_LANES (NUM_DATA_LANES),
    .ADDR_W         (ADDR_W),
    .DATA_W         (DATA_W),
    .PD_REG_ADDR    (PD_REG_ADDR),
    .PD_BIT_POS     (PD_BIT_POS),
    .SYNC_STAGES    (SYNC_STAGES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .clkValidRaw  (clkValidRaw),
    .regWrEn      (regWrEn),
    .regWrAddr    (regWrAddr),
    .regWrData    (regWrData),
    .strobe       (strobe),
    .clkValidSync (clkValidSync),
    .pdFlag       (pdFlag),
    .dataRxEn     (dataRxEn),
    .clkRxEn      (clkRxEn),
    .txEn         (txEn),
    .ddcEn        (ddcEn),
    .arcEn        (arcEn),
    .i2cEn        (i2cEn)
  );

  assign hpdSource = hpdSink;
  assign regReset  = strobe.regResetStb;
  assign linkState = strobe.state;

endmodule

// File: rtl/link_pwr_ctrl_chk.sv
module link_pwr_ctrl_chk #(
  parameter int NUM_DATA_LANES = 3
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      oePin,
  input logic [NUM_DATA_LANES-1:0] dataRxEn,
  input logic                      clkRxEn,
  input logic                      txEn,
  input logic                      ddcEn,
  input logic                      arcEn,
  input logic                      i2cEn,
  input logic                      regReset,
  input logic [1:0]                linkState
);

  // R1: OE low forces power down with control bus off
  assert_oe_low_pwrdn_R1: assert property (@(posedge clk) disable iff (!rstN)
    !oePin |=> (linkState == 2'b00) && !i2cEn);

  // R4: standby enable pattern
  assert_stby_enables_R4: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == 2'b01) |-> (clkRxEn && ddcEn && arcEn && (dataRxEn == '0)));

  // R7: transmitters off outside normal
  assert_tx_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    (linkState != 2'b10) |-> !txEn);

  // R8: OE rise yields a pulse
  assert_oe_rise_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oePin) |=> regReset);

  // R8: pulse lasts one cycle
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    regReset |=> !regReset);

  // R10: illegal code never appears
  assert_state_code_R10: assert property (@(posedge clk) disable iff (!rstN)
    linkState != 2'b11);

endmodule

bind link_pwr_ctrl link_pwr_ctrl_chk #(.NUM_DATA_LANES(NUM_DATA_LANES)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .oePin     (oePin),
  .dataRxEn  (dataRxEn),
  .clkRxEn   (clkRxEn),
  .txEn      (txEn),
  .ddcEn     (ddcEn),
  .arcEn     (arcEn),
  .i2cEn     (i2cEn),
  .regReset  (regReset),
  .linkState (linkState)
);

// File: tb/link_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_pwr_ctrl_tb_top;

  localparam int NL = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oePin = 1'b0, hpdSink = 1'b0, sigEn = 1'b0, clkValidRaw = 1'b0, retimerMode = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrAddr = 8'h00, regWrData = 8'h00;
  logic hpdSource, clkRxEn, txEn, ddcEn, arcEn, i2cEn, regReset;
  logic [NL-1:0] dataRxEn;
  logic [1:0] linkState;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  link_pwr_ctrl dut_i (
    .clk(clk), .rstN(rstN), .oePin(oePin), .hpdSink(hpdSink), .sigEn(sigEn),
    .clkValidRaw(clkValidRaw), .retimerMode(retimerMode), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .hpdSource(hpdSource),
    .dataRxEn(dataRxEn), .clkRxEn(clkRxEn), .txEn(txEn), .ddcEn(ddcEn),
    .arcEn(arcEn), .i2cEn(i2cEn), .regReset(regReset), .linkState(linkState)
  );

  // vector: {oe, hpd, sigEn, retimer, clkValid, expState[1:0]}
  localparam logic [6:0] VEC [10] = '{
    7'b0_1_1_1_1_00,  // R1 OE low
    7'b1_0_1_1_1_00,  // R2 HPD low
    7'b1_1_1_1_0_01,  // R4 retimer, no clock
    7'b1_1_0_1_0_01,  // R4 retimer, no clock, sigEn low
    7'b1_1_1_1_1_10,  // R5 retimer, clock valid
    7'b1_1_0_1_1_01,  // R4 retimer, clock valid, sigEn low
    7'b1_1_0_0_0_10,  // R6 redriver, nothing
    7'b1_1_1_0_0_10,  // R6 redriver, sigEn only
    7'b1_1_1_0_1_10,  // R6 redriver, all
    7'b0_0_0_0_0_00   // R1 all low
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chkState(input string req, input logic [1:0] st, input logic oe);
    logic n, s;
    n = (st == 2'b10);
    s = (st == 2'b01);
    chk({req, " state"}, linkState, st);
    chk({req, " dataRxEn"}, dataRxEn, n ? {NL{1'b1}} : {NL{1'b0}});
    chk({req, " clkRxEn"}, clkRxEn, n | s);
    chk({req, " txEn"}, txEn, n);
    chk({req, " ddcEn"}, ddcEn, n | s);
    chk({req, " arcEn"}, arcEn, n | s);
    chk({req, " i2cEn"}, i2cEn, oe);
    chk({req, " hpdSource R9"}, hpdSource, hpdSink);
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    edges(2);
    chk("R12 reset state", linkState, 2'b00);
    chk("R12 reset pulse", regReset, 1'b0);
    rstN = 1'b1;
    edges(2);

    // vector table
    foreach (VEC[i]) begin
      oePin = VEC[i][6]; hpdSink = VEC[i][5]; sigEn = VEC[i][4];
      retimerMode = VEC[i][3]; clkValidRaw = VEC[i][2];
      edges(4);
      chkState($sformatf("vec%0d R10", i), VEC[i][1:0], VEC[i][6]);
    end

    // R9: combinational HPD follow
    hpdSink = 1'b1; #1;
    chk("R9 hpd high", hpdSource, 1'b1);
    hpdSink = 1'b0; #1;
    chk("R9 hpd low", hpdSource, 1'b0);
    @(negedge clk);

    // R3: software power down in redriver normal
    oePin = 1'b1; hpdSink = 1'b1; retimerMode = 1'b0; sigEn = 1'b0; clkValidRaw = 1'b0;
    edges(4);
    chkState("R6 baseline", 2'b10, 1'b1);
    regWrite(8'h09, 8'h08);
    edges(2);
    chkState("R3 pd set", 2'b00, 1'b1);
    regWrite(8'h09, 8'h00);
    edges(2);
    chkState("R3 pd release", 2'b10, 1'b1);
    regWrite(8'h0A, 8'h08);
    edges(2);
    chk("R3 other address ignored", linkState, 2'b10);
    regWrite(8'h09, 8'hF7);
    edges(2);
    chk("R3 other bits ignored", linkState, 2'b10);

    // R8: OE rise pulse and flag clear
    regWrite(8'h09, 8'h08);
    edges(2);
    chk("R8 pd set before cycle", linkState, 2'b00);
    oePin = 1'b0;
    edges(3);
    chk("R1 oe low", linkState, 2'b00);
    chk("R1 i2c off", i2cEn, 1'b0);
    chk("R8 no pulse while low", regReset, 1'b0);
    oePin = 1'b1;
    edges(1);
    chk("R8 pulse high", regReset, 1'b1);
    edges(1);
    chk("R8 pulse low", regReset, 1'b0);
    edges(2);
    chk("R8 flag cleared", linkState, 2'b10);

    // R11: synchronizer latency in retimer mode
    retimerMode = 1'b1; sigEn = 1'b1; clkValidRaw = 1'b0;
    edges(4);
    chk("R4 standby start", linkState, 2'b01);
    clkValidRaw = 1'b1;
    edges(2);
    chk("R11 still standby at edge 2", linkState, 2'b01);
    edges(1);
    chk("R11 normal at edge 3", linkState, 2'b10);
    clkValidRaw = 1'b0;
    edges(2);
    chk("R11 still normal at edge 2", linkState, 2'b10);
    edges(1);
    chk("R11 standby at edge 3", linkState, 2'b01);

    // R2: HPD low with OE high keeps control bus on
    hpdSink = 1'b0;
    edges(2);
    chkState("R2 hpd low", 2'b00, 1'b1);

    // R12: reset mid-run clears flag
    hpdSink = 1'b1; retimerMode = 1'b0;
    regWrite(8'h09, 8'h08);
    rstN = 1'b0;
    edges(1);
    chk("R12 reset state mid-run", linkState, 2'b00);
    rstN = 1'b1;
    edges(3);
    chk("R12 flag cleared by reset", linkState, 2'b10);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule